// File: doc/BRIEF.md
# Data-Rate Switch Reset Sequencer

This block is the reset sequencer for one serial transceiver lane whose transmit PLL is reprogrammed to move the lane to a new line rate. The lane runs as a single lane, and its receive clock recovery locks by itself. When a switch is requested, the sequencer puts the lane into reset. It then waits, for as long as needed, for the PLL programming logic to report that the new settings have been loaded. It acknowledges that event, restarts the PLL with a short analog reset, and brings the lane back up.

The lane comes back up in a fixed order. The transmit digital reset is removed once the PLL reports lock. The receive analog reset follows one cycle later. Receive frequency lock is then watched, and the receive digital reset is removed only after frequency lock has held for a programmable settling interval. If either lock drops while the lane is coming back up, all three lane resets return at once and the bring-up restarts from the PLL-lock wait.

Outputs are registered and the reset is synchronous and active high. A busy flag covers the whole procedure, and start requests are ignored while it is high.

Top module: `rate_switch_reset_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is low.
- R2: A `start_req` seen while idle raises `busy`, `tx_dig_rst`, `rx_ana_rst` and `rx_dig_rst` together on the next cycle, with `pll_arst` and `reconfig_done` still low. `cfg_update` sampled in the same idle cycle has no effect.
- R3: After start, the block waits for `cfg_update` for any number of cycles. The cycle after `cfg_update` is sampled, `reconfig_done` is high for exactly one cycle.
- R4: `pll_arst` rises in the cycle right after the `reconfig_done` pulse and stays high for exactly `PLL_RST_CYCLES` cycles (default 5). The three lane resets stay high throughout.
- R5: `pll_locked` is ignored until `pll_arst` has fallen. After that, `tx_dig_rst` falls on the cycle after `pll_locked` is first sampled high.
- R6: `rx_ana_rst` falls one cycle after `tx_dig_rst` if `pll_locked` is still high. `freq_locked` is ignored before `rx_ana_rst` has fallen.
- R7: Once `rx_ana_rst` is low, `rx_dig_rst` and `busy` fall together on the (`LTD_CYCLES`+1)-th consecutive rising edge at which `freq_locked` is sampled high. The count restarts whenever `freq_locked` falls.
- R8: After `tx_dig_rst` has been released, a low `pll_locked` reasserts all three lane resets on the next cycle. A low `freq_locked` does the same once the settling count has begun. Neither event produces a new `reconfig_done` or `pll_arst`, and bring-up then restarts at the PLL-lock wait.
- R9: `start_req` has no effect while `busy` is high.
- R10: If a lock drop lands on the final cycle of the settling count, the drop wins: the resets are reasserted and `rx_dig_rst` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to begin a data-rate switch |
| cfg_update | input | 1 | Strobe: new PLL settings have been shifted in and loaded |
| pll_locked | input | 1 | Transmit PLL lock flag |
| freq_locked | input | 1 | Receive clock recovery frequency-lock flag |
| busy | output | 1 | Procedure in progress |
| tx_dig_rst | output | 1 | Transmit digital reset |
| rx_ana_rst | output | 1 | Receive analog reset |
| rx_dig_rst | output | 1 | Receive digital reset |
| reconfig_done | output | 1 | One-cycle acknowledge that the PLL programming has finished |
| pll_arst | output | 1 | PLL analog reset |

## Verification
The key collision is between the settling counter reaching its end and a drop in `freq_locked` on that same cycle. One transition would release the receive digital reset; the other would put all lane resets back. The stimulus table drops `freq_locked` exactly on the cycle in which the counter reaches its terminal value. The bench judges the result as correct only if, on the following cycle, all three lane resets are high and `busy` is still high. A second overlap, `start_req` and `cfg_update` arriving together in the idle state, is also driven. The expected result is that only the start takes effect.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_ACK  = 3'd2,
    ST_PRST = 3'd3,
    ST_WPLL = 3'd4,
    ST_TXUP = 3'd5,
    ST_WFRQ = 3'd6,
    ST_SETL = 3'd7
  } seq_state_t;

  typedef struct packed {
    logic busy;
    logic tx_dig;
    logic rx_ana;
    logic rx_dig;
    logic ack;
    logic pll_rst;
  } ctl_t;

  function automatic ctl_t decode_state(input seq_state_t s);
    ctl_t c;
    c = '0;
    case (s)
      ST_IDLE: c = '0;
      ST_HOLD: c = '{busy: 1'b1, tx_dig: 1'b1, rx_ana: 1'b1, rx_dig: 1'b1, ack: 1'b0, pll_rst: 1'b0};
      ST_ACK:  c = '{busy: 1'b1, tx_dig: 1'b1, rx_ana: 1'b1, rx_dig: 1'b1, ack: 1'b1, pll_rst: 1'b0};
      ST_PRST: c = '{busy: 1'b1, tx_dig: 1'b1, rx_ana: 1'b1, rx_dig: 1'b1, ack: 1'b0, pll_rst: 1'b1};
      ST_WPLL: c = '{busy: 1'b1, tx_dig: 1'b1, rx_ana: 1'b1, rx_dig: 1'b1, ack: 1'b0, pll_rst: 1'b0};
      ST_TXUP: c = '{busy: 1'b1, tx_dig: 1'b0, rx_ana: 1'b1, rx_dig: 1'b1, ack: 1'b0, pll_rst: 1'b0};
      ST_WFRQ: c = '{busy: 1'b1, tx_dig: 1'b0, rx_ana: 1'b0, rx_dig: 1'b1, ack: 1'b0, pll_rst: 1'b0};
      ST_SETL: c = '{busy: 1'b1, tx_dig: 1'b0, rx_ana: 1'b0, rx_dig: 1'b1, ack: 1'b0, pll_rst: 1'b0};
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rsq_interval.sv
// Counts cycles spent in one state; flags the last cycle of a LIMIT-cycle stay.
module rsq_interval #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic last
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt <= '0;
    end else if (cnt != TOP) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = active && (cnt == TOP);
endmodule

// File: rtl/rsq_fsm.sv
// Sequencing state register and next-state decision.
module rsq_fsm
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_req,
  input  logic       cfg_update,
  input  logic       pll_locked,
  input  logic       freq_locked,
  input  logic       prst_last,
  input  logic       setl_last,
  output seq_state_t st,
  output seq_state_t st_nxt
);
  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: if (start_req) st_nxt = ST_HOLD;
      ST_HOLD: if (cfg_update) st_nxt = ST_ACK;
      ST_ACK:  st_nxt = ST_PRST;
      ST_PRST: if (prst_last) st_nxt = ST_WPLL;
      ST_WPLL: if (pll_locked) st_nxt = ST_TXUP;
      ST_TXUP: st_nxt = pll_locked ? ST_WFRQ : ST_WPLL;
      ST_WFRQ: begin
        if (!pll_locked)      st_nxt = ST_WPLL;
        else if (freq_locked) st_nxt = ST_SETL;
      end
      ST_SETL: begin
        // a lock loss outranks the end of the settling interval
        if (!pll_locked || !freq_locked) st_nxt = ST_WPLL;
        else if (setl_last)              st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/rsq_outreg.sv
// Output flops loaded from the decode of the next state.
module rsq_outreg
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t st_nxt,
  output ctl_t       ctl
);
  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else     ctl <= decode_state(st_nxt);
  end
endmodule

// File: rtl/rate_switch_reset_seq.sv
module rate_switch_reset_seq
  import rsq_pkg::*;
#(
  parameter int PLL_RST_CYCLES = 5,
  parameter int LTD_CYCLES     = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic cfg_update,
  input  logic pll_locked,
  input  logic freq_locked,
  output logic busy,
  output logic tx_dig_rst,
  output logic rx_ana_rst,
  output logic rx_dig_rst,
  output logic reconfig_done,
  output logic pll_arst
);
  seq_state_t st, st_nxt;
  logic       prst_last, setl_last;
  ctl_t       ctl;

  rsq_interval #(.LIMIT(PLL_RST_CYCLES)) u_prst_timer (
    .clk(clk), .rst(rst), .active(st == ST_PRST), .last(prst_last)
  );

  rsq_interval #(.LIMIT(LTD_CYCLES)) u_setl_timer (
    .clk(clk), .rst(rst), .active(st == ST_SETL), .last(setl_last)
  );

  rsq_fsm u_fsm (
    .clk(clk), .rst(rst), .start_req(start_req), .cfg_update(cfg_update),
    .pll_locked(pll_locked), .freq_locked(freq_locked),
    .prst_last(prst_last), .setl_last(setl_last), .st(st), .st_nxt(st_nxt)
  );

  rsq_outreg u_out (.clk(clk), .rst(rst), .st_nxt(st_nxt), .ctl(ctl));

  assign busy          = ctl.busy;
  assign tx_dig_rst    = ctl.tx_dig;
  assign rx_ana_rst    = ctl.rx_ana;
  assign rx_dig_rst    = ctl.rx_dig;
  assign reconfig_done = ctl.ack;
  assign pll_arst      = ctl.pll_rst;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int PLL_RST_CYCLES = 5
) (
  input logic clk,
  input logic rst,
  input logic start_req,
  input logic pll_locked,
  input logic freq_locked,
  input logic busy,
  input logic tx_dig_rst,
  input logic rx_ana_rst,
  input logic rx_dig_rst,
  input logic reconfig_done,
  input logic pll_arst
);
  localparam int RW = $clog2(PLL_RST_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || !pll_arst) run <= '0;
    else if (run != {RW{1'b1}}) run <= run + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !(busy || tx_dig_rst || rx_ana_rst || rx_dig_rst || reconfig_done || pll_arst));

  assert_start_resets_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (tx_dig_rst && rx_ana_rst && rx_dig_rst && !pll_arst && !reconfig_done));

  assert_idle_start_R2: assert property (@(posedge clk) disable iff (rst)
    (start_req && !busy) |=> busy);

  assert_ack_single_R3: assert property (@(posedge clk) disable iff (rst)
    reconfig_done |=> (!reconfig_done && pll_arst));

  assert_prst_bound_R4: assert property (@(posedge clk) disable iff (rst)
    pll_arst |-> (run < RW'(PLL_RST_CYCLES)));

  assert_prst_length_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(pll_arst) && !$past(rst)) |-> (run == RW'(PLL_RST_CYCLES)));

  assert_tx_release_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(tx_dig_rst) && !$past(rst)) |-> ($past(pll_locked) && !pll_arst));

  assert_rxa_order_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_ana_rst) && !$past(rst)) |-> (!tx_dig_rst && $past(pll_locked)));

  assert_rxd_release_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_dig_rst) && !$past(rst)) |-> (!busy && $past(freq_locked) && !rx_ana_rst));

  assert_pll_loss_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !tx_dig_rst && !pll_locked) |=> (tx_dig_rst && rx_ana_rst && rx_dig_rst && !reconfig_done && !pll_arst));
endmodule

bind rate_switch_reset_seq rsq_checker #(.PLL_RST_CYCLES(PLL_RST_CYCLES)) u_rsq_checker (
  .clk(clk), .rst(rst), .start_req(start_req), .pll_locked(pll_locked),
  .freq_locked(freq_locked), .busy(busy), .tx_dig_rst(tx_dig_rst),
  .rx_ana_rst(rx_ana_rst), .rx_dig_rst(rx_dig_rst),
  .reconfig_done(reconfig_done), .pll_arst(pll_arst)
);

// File: tb/test_rate_switch_reset_seq.sv
module test_rate_switch_reset_seq;
  localparam int NV = 51;

  logic clk = 1'b0;
  logic rst, start_req, cfg_update, pll_locked, freq_locked;
  logic busy, tx_dig_rst, rx_ana_rst, rx_dig_rst, reconfig_done, pll_arst;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rate_switch_reset_seq #(.PLL_RST_CYCLES(5), .LTD_CYCLES(4)) i_rate_switch_reset_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .cfg_update(cfg_update),
    .pll_locked(pll_locked), .freq_locked(freq_locked), .busy(busy),
    .tx_dig_rst(tx_dig_rst), .rx_ana_rst(rx_ana_rst), .rx_dig_rst(rx_dig_rst),
    .reconfig_done(reconfig_done), .pll_arst(pll_arst)
  );

  // row: {start,cfg,pll_lock,freq_lock} {busy,tx,rxa,rxd,done,arst} {req}
  localparam logic [13:0] VEC [NV] = '{
    {4'b1000, 6'b111100, 4'd2},   // R2 start from idle
    {4'b0000, 6'b111100, 4'd3},   // R3 waiting for cfg_update
    {4'b0011, 6'b111100, 4'd5},   // R5 locks ignored while holding
    {4'b0100, 6'b111110, 4'd3},   // R3 ack pulse
    {4'b0010, 6'b111101, 4'd4},   // R4 pll reset 1
    {4'b0010, 6'b111101, 4'd4},
    {4'b0010, 6'b111101, 4'd4},
    {4'b0010, 6'b111101, 4'd4},
    {4'b0010, 6'b111101, 4'd4},   // R4 pll reset 5
    {4'b0000, 6'b111100, 4'd4},
    {4'b0000, 6'b111100, 4'd5},
    {4'b0010, 6'b101100, 4'd5},   // R5 tx release
    {4'b0010, 6'b100100, 4'd6},   // R6 rx analog release
    {4'b0010, 6'b100100, 4'd6},
    {4'b0011, 6'b100100, 4'd7},   // R7 settling
    {4'b0011, 6'b100100, 4'd7},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0011, 6'b000000, 4'd7},   // R7 rx digital release
    {4'b1011, 6'b111100, 4'd2},
    {4'b1011, 6'b111100, 4'd9},   // R9 start while busy
    {4'b0111, 6'b111110, 4'd3},
    {4'b0011, 6'b111101, 4'd4},
    {4'b0011, 6'b111101, 4'd4},
    {4'b0011, 6'b111101, 4'd4},
    {4'b0011, 6'b111101, 4'd4},
    {4'b0011, 6'b111101, 4'd4},
    {4'b0011, 6'b111100, 4'd4},
    {4'b0011, 6'b101100, 4'd5},
    {4'b0001, 6'b111100, 4'd8},   // R8 pll lock loss
    {4'b0011, 6'b101100, 4'd5},
    {4'b0011, 6'b100100, 4'd6},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0010, 6'b111100, 4'd8},   // R8 freq lock loss
    {4'b0011, 6'b101100, 4'd8},
    {4'b0011, 6'b100100, 4'd6},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0010, 6'b111100, 4'd10},  // R10 drop on terminal count
    {4'b0011, 6'b101100, 4'd5},
    {4'b0011, 6'b100100, 4'd6},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0011, 6'b100100, 4'd7},
    {4'b0011, 6'b000000, 4'd7},
    {4'b1100, 6'b111100, 4'd2},   // R2 cfg in idle ignored
    {4'b0000, 6'b111100, 4'd3},
    {4'b0100, 6'b111110, 4'd3}
  };

  function automatic logic [5:0] outs();
    return {busy, tx_dig_rst, rx_ana_rst, rx_dig_rst, reconfig_done, pll_arst};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] in);
    @(negedge clk);
    {start_req, cfg_update, pll_locked, freq_locked} = in;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1;
    {start_req, cfg_update, pll_locked, freq_locked} = 4'b0000;
    repeat (3) @(posedge clk);
    #1 check("R1", outs(), 6'b000000);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #1 check("R1", outs(), 6'b000000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13:10]);
      check($sformatf("R%0d row %0d", VEC[i][3:0], i), outs(), VEC[i][9:4]);
    end

    // R4 / R1: reset in the middle of the PLL reset pulse
    step(4'b0000);
    check("R4", outs(), 6'b111101);
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 check("R1", outs(), 6'b000000);
    @(negedge clk) rst = 1'b0;
    step(4'b0011);
    check("R1", outs(), 6'b000000);

    // R3: arbitrarily long wait for cfg_update
    step(4'b1000);
    begin
      bit bad = 1'b0;
      for (int k = 0; k < 150; k++) begin
        step(4'b0011);
        if (outs() !== 6'b111100) bad = 1'b1;
      end
      check("R3 long wait", {5'b0, bad}, 6'b000000);
    end
    step(4'b0100);
    check("R3", outs(), 6'b111110);
    step(4'b0000);
    check("R3", outs(), 6'b111101);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule